// File: doc/BRIEF.md
# Redundant Fault-Detecting Equality Gate

This block decides whether two operand words are equal, for use where the decision opens a security-sensitive step such as deriving a key or moving to a new life-cycle state. The decision is made twice. A primary path compares the operands that were registered when the request was accepted. A second path compares bit-inverted copies of the operands, and it takes those copies from the operand ports several cycles later. A decision is released only when both paths produce the same well-formed answer. If they differ, or if either answer is not a legal code, the block pulses an alert towards the escalation logic and withholds the grant.

The grant is carried as a 4-bit code with a large Hamming distance between its two legal values. 4'b1010 means granted and 4'b0101 means not granted. The internal results from each path use the same two codes, and any other pattern counts as a fault. The time from an accepted start to `done_o` is the same for every operand value, so the response time reveals nothing about the comparison. The requester must keep the operand ports steady until the redundant sample has been taken. A change inside that window is treated as a transient fault.

Top module: `redcmp_gate`

## Requirements
- R1: While reset is held, and after it is released, `grant_o` is 4'b0101, `done_o` is 0 and `alert_o` is 0.
- R2: When the operands are equal and both paths agree, `done_o` and `grant_o` = 4'b1010 appear for one cycle, exactly RED_DLY+2 clock edges after the edge that accepted `start_i`, and `alert_o` stays 0.
- R3: When the operands differ and both paths agree, `done_o` pulses with `grant_o` = 4'b0101 and `alert_o` = 0.
- R4: `done_o` stays low until RED_DLY+2 edges after acceptance, whatever the operand values.
- R5: `grant_o` shows 4'b1010 only in a cycle in which `done_o` is 1, and shows 4'b0101 at all other times.
- R6: The redundant path samples the inverted operand ports on the edge RED_DLY edges after acceptance. If its result differs from the primary result, the done cycle carries `alert_o` = 1 and `grant_o` = 4'b0101.
- R7: A `start_i` seen while a comparison is in progress is ignored, including its operands. It raises `alert_o` for one cycle on the following edge, and the ongoing comparison finishes with its own result.
- R8: A `start_i` driven in the cycle in which `done_o` is visible is accepted as a new comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a comparison |
| op_a_i | input | W | First operand |
| op_b_i | input | W | Second operand |
| grant_o | output | 4 | Decision code: 4'b1010 granted, 4'b0101 not granted |
| done_o | output | 1 | One-cycle pulse marking a finished comparison |
| alert_o | output | 1 | One-cycle fault pulse to the escalation handler |

## Verification
The hardest state to reach from the ports is disagreement between the primary and redundant results, because both paths see the same operands in normal use. The bench reaches it by changing an operand word after the accepting edge but before the redundant sample edge. It does this in both directions, so that equal-then-unequal and unequal-then-equal each produce an alert with the grant withheld. A start that arrives while busy is placed after the redundant sample and carries different operands, so that the bench can show that those operands left the outcome untouched.

// File: rtl/redcmp_gate.sv
module redcmp_gate #(
  parameter int W       = 32,
  parameter int RED_DLY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [3:0]   grant_o,
  output logic         done_o,
  output logic         alert_o
);
  localparam logic [3:0] C_T = 4'b1010;
  localparam logic [3:0] C_F = 4'b0101;
  localparam int CW = $clog2(RED_DLY + 2) + 1;
  localparam logic [CW-1:0] CAP_C = CW'(RED_DLY - 1);
  localparam logic [CW-1:0] RED_C = CW'(RED_DLY);
  localparam logic [CW-1:0] FIN_C = CW'(RED_DLY + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  pa_q, pb_q, ra_q, rb_q;
  logic [3:0]    prim_q, red_q, grant_q;
  logic          done_q, alert_q;

  logic accept, fin, agree_t, sane, bad;

  assign accept  = start_i && !busy_q;
  assign fin     = busy_q && (cnt_q == FIN_C);
  assign sane    = (prim_q == C_T) || (prim_q == C_F);
  assign agree_t = (prim_q == C_T) && (red_q == C_T);
  assign bad     = !sane || (prim_q != red_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
      prim_q  <= 4'b0000;
      red_q   <= 4'b0000;
      grant_q <= C_F;
      done_q  <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      grant_q <= C_F;
      alert_q <= (start_i && busy_q) || (fin && bad);
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pa_q   <= op_a_i;
        pb_q   <= op_b_i;
        prim_q <= 4'b0000;
        red_q  <= 4'b0000;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0)
          prim_q <= (pa_q == pb_q) ? C_T : C_F;
        if (cnt_q == CAP_C) begin
          ra_q <= ~op_a_i;
          rb_q <= ~op_b_i;
        end
        if (cnt_q == RED_C)
          red_q <= (ra_q == rb_q) ? C_T : C_F;
        if (fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (agree_t && !bad)
            grant_q <= C_T;
        end
      end
    end
  end

  assign grant_o = grant_q;
  assign done_o  = done_q;
  assign alert_o = alert_q;

  initial begin
    assert (RED_DLY >= 1) else $error("RED_DLY must be at least 1");
  end

  p_grant_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == C_T) || (grant_o == C_F));
  p_grant_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == C_T) |-> done_o);
  p_grant_no_alert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == C_T) |-> !alert_o);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_from_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_q));
  p_mismatch_withheld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && alert_o) |-> (grant_o == C_F));
  p_busy_start_alert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> alert_o);
  p_busy_holds_ops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(pa_q) && $stable(pb_q)));
endmodule

// File: tb/sim_redcmp_gate.sv
module sim_redcmp_gate;
  localparam int W  = 32;
  localparam int RD = 2;
  localparam logic [3:0] GT = 4'b1010;
  localparam logic [3:0] GF = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0] grant;
  logic done, alert;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  redcmp_gate #(.W(W), .RED_DLY(RD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_a_i(a), .op_b_i(b),
    .grant_o(grant), .done_o(done), .alert_o(alert));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    waitn(2);
    chk("R1 grant in reset", grant, GF);
    chk("R1 done in reset", {3'b0, done}, 4'd0);
    chk("R1 alert in reset", {3'b0, alert}, 4'd0);
    rst_n = 1'b1;
    waitn(1);
    chk("R1 grant after reset", grant, GF);
    chk("R1 alert after reset", {3'b0, alert}, 4'd0);
  endtask

  task automatic t_run(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [3:0] exp;
    exp = (x == y) ? GT : GF;
    go(x, y);
    waitn(RD + 1);
    chk({tag, " R4 no early done"}, {3'b0, done}, 4'd0);
    chk({tag, " R5 idle grant"}, grant, GF);
    waitn(1);
    chk({tag, " R4 done on time"}, {3'b0, done}, 4'd1);
    chk({tag, (x == y) ? " R2 grant" : " R3 deny"}, grant, exp);
    chk({tag, " R3 no alert"}, {3'b0, alert}, 4'd0);
    waitn(1);
    chk({tag, " R5 grant drops"}, grant, GF);
    chk({tag, " R2 done pulse"}, {3'b0, done}, 4'd0);
  endtask

  task automatic t_glitch(input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] y2);
    go(x, y);
    b = y2;
    waitn(RD + 2);
    chk("R6 done on mismatch", {3'b0, done}, 4'd1);
    chk("R6 alert on mismatch", {3'b0, alert}, 4'd1);
    chk("R6 grant withheld", grant, GF);
    waitn(1);
    chk("R6 alert pulse", {3'b0, alert}, 4'd0);
  endtask

  task automatic t_busy;
    go(32'h1234_5678, 32'h1234_5678);
    waitn(RD);
    a = 32'hAAAA_0000; b = 32'h0000_5555; start = 1'b1;
    waitn(1);
    start = 1'b0;
    chk("R7 busy start alert", {3'b0, alert}, 4'd1);
    chk("R7 no done yet", {3'b0, done}, 4'd0);
    waitn(1);
    chk("R7 first result kept", grant, GT);
    chk("R7 done", {3'b0, done}, 4'd1);
    chk("R7 alert pulse ends", {3'b0, alert}, 4'd0);
    waitn(RD + 2);
    chk("R7 ignored start no done", {3'b0, done}, 4'd0);
  endtask

  task automatic t_b2b;
    go(32'h0F0F_0F0F, 32'h0F0F_0F0F);
    waitn(RD + 2);
    chk("R8 first done", grant, GT);
    a = 32'h7; b = 32'h7; start = 1'b1;
    waitn(1);
    start = 1'b0;
    chk("R8 accepted no alert", {3'b0, alert}, 4'd0);
    waitn(RD + 2);
    chk("R8 second done", {3'b0, done}, 4'd1);
    chk("R8 second grant", grant, GT);
  endtask

  initial begin
    t_reset();
    t_run("eq", 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    t_run("zero", 32'h0, 32'h0);
    t_run("lsb", 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    t_run("msb", 32'h8000_0001, 32'h0000_0001);
    t_glitch(32'h55, 32'h55, 32'h54);
    t_glitch(32'h55, 32'h57, 32'h55);
    t_busy();
    t_b2b();
    waitn(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule